// File: doc/BRIEF.md
# Buffered Asynchronous Serial Channel

This block is one full-duplex asynchronous serial channel. Characters written by the host pass through a small transmit queue and leave on `txd`. Characters arriving on `rxd` are framed, checked and held in a receive queue until the host reads them. The two directions are paced by separate clock-enable inputs, `tx_tick` and `rx_tick`. Each direction can treat its tick as the bit rate (1x) or as sixteen times the bit rate (16x). Rate generation and bus decoding are left to the surrounding logic.

A frame is a low start bit, eight data bits sent least significant first, an optional ninth bit, and a high stop bit. The ninth bit carries even parity, odd parity or a multidrop address/data flag. In 16x transmit mode the stop bit can be stretched in sixteenths of a bit. Four channel modes route the serial lines for normal operation, automatic echo, local loopback and remote loopback. The active-low ready-to-send output `rts_n` goes high while the receive queue is full, so a remote sender can pause before data is lost.

The host sees four byte-wide locations, selected by `addr`. All reads are combinational; a read of address 0 with `rd_en` high removes the oldest received character.

| addr | write | read |
|------|-------|------|
| 0 | data to transmit | oldest received character |
| 1 | mode register | mode register |
| 2 | command (bit 0 clears overrun) | status |
| 3 | stop fraction F in bits 3:0 | stop fraction F |

Mode register fields:
- bits 1:0 select the ninth bit: 0 none, 1 even parity, 2 odd parity, 3 multidrop.
- bits 3:2 select the channel mode: 0 normal, 1 echo, 2 local loopback, 3 remote loopback.
- bit 4 sets receive 16x.
- bit 5 sets transmit 16x.
- bit 7 is the transmit address flag used in multidrop mode.

Status bits:
- bit 0: receive data available
- bit 1: receive queue full
- bit 2: transmit queue has space
- bit 3: transmitter idle
- bit 4: overrun
- bit 5: parity error of the oldest character
- bit 6: framing error of the oldest character
- bit 7: ninth bit of the oldest character

Top module: `sio_channel`

## Requirements
- R1: After reset the status reads 0x0C, the mode register reads 0, `txd` is high and `rts_n` is low.
- R2: The transmitter sends each queued character in write order as a low start bit, eight data bits least significant first, the ninth bit when mode bits 1:0 are non-zero, and a high stop bit. In 1x mode each bit lasts one `tx_tick`.
- R3: The transmit queue holds 4 characters. A data write while it is full is dropped. Status bit 2 is clear while the queue is full, and status bit 3 is set only when the queue is empty and no frame is in progress.
- R4: A received frame enters the receive queue. Reading address 0 with `rd_en` returns the oldest character and removes it. Status bit 0 shows that data is present and bit 1 shows that 4 characters are held.
- R5: `rts_n` is high exactly while the receive queue holds 4 characters and low otherwise.
- R6: A character that completes while 4 characters are held is discarded and sets status bit 4. Bit 4 stays set until address 2 is written with bit 0 set.
- R7: With mode bits 1:0 = 1 the transmitted ninth bit is even parity over the data; with value 2 it is odd parity. A received character whose ninth bit mismatches is flagged in status bit 5 while it is the oldest entry.
- R8: A received character whose stop-bit sample is low is flagged in status bit 6 while it is the oldest entry.
- R9: With mode bits 1:0 = 3 the ninth transmitted bit is the value of mode bit 7 at the time of the data write. The received ninth bit is reported in status bit 7.
- R10: Mode bit 4 selects 16x receive and mode bit 5 selects 16x transmit; in 16x mode each bit spans 16 ticks. The two directions run from their own tick inputs with independent settings.
- R11: In 16x receive mode the start bit is re-sampled 8 ticks after the low level is first seen. If the line is high at that point, the event is dropped and no character is stored.
- R12: In 16x transmit mode the stop bit lasts 16+F ticks, where F is the value at address 3. Back-to-back frames without a ninth bit therefore start 160+F ticks apart. In 1x mode the stop bit is one tick whatever F is.
- R13: In echo mode (mode bits 3:2 = 1) and remote loopback (value 3), `txd` follows `rxd` and host data writes are dropped. Echo mode still stores received characters; remote loopback stores none.
- R14: In local loopback (value 2) the transmitter output feeds the receiver, so written characters are received back, and `txd` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| wr_en | input | 1 | register write strobe |
| rd_en | input | 1 | register read strobe (removes a character at address 0) |
| addr | input | 2 | register select |
| wdata | input | 8 | write data |
| rdata | output | 8 | read data, combinational from `addr` |
| rx_tick | input | 1 | receive clock enable (bit rate or 16x) |
| tx_tick | input | 1 | transmit clock enable (bit rate or 16x) |
| rxd | input | 1 | serial input |
| txd | output | 1 | serial output |
| rts_n | output | 1 | ready to send, active low, high when the receive queue is full |

## Verification
The bench builds the channel with DEPTH = 4. This makes the full queue, the `rts_n` flip and overrun reachable after four frames, and lets a fifth write show a dropped character. Tick dividers of 3 to 5 clocks keep 16x frames short, so the glitch rejection, the 16+F stop length and a split-rate run (16x receive against 1x transmit on different dividers) all fit in a few thousand cycles. A serial model on `txd` pops expected frames from a scoreboard queue, so any extra or missing frame, including one leaked from echo mode, is reported.

// File: rtl/sio_channel.sv
module sio_channel #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       rx_tick,
  input  logic       tx_tick,
  input  logic       rxd,
  output logic       txd,
  output logic       rts_n
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [1:0] M_NORM = 2'd0, M_ECHO = 2'd1, M_LOCAL = 2'd2, M_REMOTE = 2'd3;
  localparam logic [1:0] P_NONE = 2'd0, P_EVEN = 2'd1, P_ODD = 2'd2, P_ADDR = 2'd3;

  logic [7:0] mode;
  logic [3:0] stop_frac;
  logic       ovr;

  wire [1:0] par  = mode[1:0];
  wire [1:0] chm  = mode[3:2];
  wire       rx16 = mode[4];
  wire       tx16 = mode[5];
  wire       xbit = par != P_NONE;
  wire [3:0] stop_idx = xbit ? 4'd10 : 4'd9;
  wire       ovr_clr = wr_en && addr == 2'd2 && wdata[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode <= '0;
      stop_frac <= '0;
    end else if (wr_en) begin
      if (addr == 2'd1) mode <= wdata;
      if (addr == 2'd3) stop_frac <= wdata[3:0];
    end

  // transmit queue and shifter
  logic [8:0]    txq [DEPTH];
  logic [PW-1:0] txw, txr;
  logic [CW-1:0] txn;
  logic          tx_busy;
  logic [3:0]    tx_idx;
  logic [4:0]    tx_sub;
  logic [8:0]    tx_hold;
  logic          tx_line;

  wire       tx_host = chm == M_NORM || chm == M_LOCAL;
  wire       tx_push = wr_en && addr == 2'd0 && tx_host && txn != CW'(DEPTH);
  wire [8:0] tx_head = txq[txr];
  wire       tx_x = par == P_EVEN ? ^tx_head[7:0] :
                    par == P_ODD  ? ~^tx_head[7:0] : tx_head[8];
  wire [4:0] tx_end = !tx16 ? 5'd0 :
                      (tx_idx == stop_idx) ? 5'd15 + {1'b0, stop_frac} : 5'd15;
  wire       tx_done = tx_busy && tx_tick && tx_sub == tx_end && tx_idx == stop_idx;
  wire       tx_pop  = tx_tick && txn != '0 && (!tx_busy || tx_done);
  wire       tx_idle = txn == '0 && !tx_busy;

  always_comb begin
    if (!tx_busy || tx_idx == stop_idx) tx_line = 1'b1;
    else if (tx_idx == 4'd0)            tx_line = 1'b0;
    else if (tx_idx <= 4'd8)            tx_line = tx_hold[tx_idx - 4'd1];
    else                                tx_line = tx_hold[8];
  end

  always_ff @(posedge clk) if (tx_push) txq[txw] <= {mode[7], wdata};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      txw <= '0;
      txr <= '0;
      txn <= '0;
    end else begin
      if (tx_push) txw <= (txw == PW'(DEPTH - 1)) ? '0 : txw + 1'b1;
      if (tx_pop)  txr <= (txr == PW'(DEPTH - 1)) ? '0 : txr + 1'b1;
      txn <= txn + CW'(tx_push) - CW'(tx_pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_idx  <= '0;
      tx_sub  <= '0;
      tx_hold <= '0;
    end else if (tx_pop) begin
      tx_busy <= 1'b1;
      tx_idx  <= '0;
      tx_sub  <= '0;
      tx_hold <= {tx_x, tx_head[7:0]};
    end else if (tx_done) begin
      tx_busy <= 1'b0;
    end else if (tx_busy && tx_tick) begin
      if (tx_sub == tx_end) begin
        tx_sub <= '0;
        tx_idx <= tx_idx + 4'd1;
      end else tx_sub <= tx_sub + 5'd1;
    end

  // receiver and receive queue
  logic          rx_busy;
  logic [3:0]    rx_idx;
  logic [3:0]    rx_sub;
  logic [8:0]    rx_sh;
  logic [10:0]   rxq [DEPTH];
  logic [PW-1:0] rxw, rxr;
  logic [CW-1:0] rxn;

  wire rx_in  = (chm == M_LOCAL) ? tx_line : rxd;
  wire rx_smp = rx_tick && rx_busy && (!rx16 || rx_sub == 4'd15);
  wire rx_fin = rx_smp && rx_idx == stop_idx;
  wire rx_pe  = (par == P_EVEN && rx_sh[8] != ^rx_sh[7:0]) ||
                (par == P_ODD  && rx_sh[8] != ~^rx_sh[7:0]);
  wire rx_keep = rx_fin && chm != M_REMOTE;
  wire rx_push = rx_keep && rxn != CW'(DEPTH);
  wire rx_pop  = rd_en && addr == 2'd0 && rxn != '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_busy <= 1'b0;
      rx_idx  <= '0;
      rx_sub  <= '0;
      rx_sh   <= '0;
    end else if (!rx_busy) begin
      if (rx_tick && !rx_in) begin
        rx_busy <= 1'b1;
        rx_sh   <= '0;
        rx_idx  <= rx16 ? 4'd0 : 4'd1;
        rx_sub  <= 4'd8;
      end
    end else if (rx_smp) begin
      rx_sub <= '0;
      if (rx_idx == 4'd0) begin
        if (rx_in) rx_busy <= 1'b0;
        else       rx_idx  <= 4'd1;
      end else if (rx_idx == stop_idx) begin
        rx_busy <= 1'b0;
      end else begin
        rx_sh[rx_idx - 4'd1] <= rx_in;
        rx_idx <= rx_idx + 4'd1;
      end
    end else if (rx_tick) rx_sub <= rx_sub + 4'd1;

  always_ff @(posedge clk)
    if (rx_push) rxq[rxw] <= {par == P_ADDR && rx_sh[8], !rx_in, rx_pe, rx_sh[7:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rxw <= '0;
      rxr <= '0;
      rxn <= '0;
      ovr <= 1'b0;
    end else begin
      if (rx_push) rxw <= (rxw == PW'(DEPTH - 1)) ? '0 : rxw + 1'b1;
      if (rx_pop)  rxr <= (rxr == PW'(DEPTH - 1)) ? '0 : rxr + 1'b1;
      rxn <= rxn + CW'(rx_push) - CW'(rx_pop);
      if (rx_keep && !rx_push) ovr <= 1'b1;
      else if (ovr_clr)        ovr <= 1'b0;
    end

  wire [10:0] rx_head = rxq[rxr];
  wire        rx_av   = rxn != '0;

  always_comb
    case (addr)
      2'd0:    rdata = rx_head[7:0];
      2'd1:    rdata = mode;
      2'd2:    rdata = {rx_av & rx_head[10], rx_av & rx_head[9], rx_av & rx_head[8], ovr,
                        tx_idle, txn != CW'(DEPTH), rxn == CW'(DEPTH), rx_av};
      default: rdata = {4'd0, stop_frac};
    endcase

  assign txd   = (chm == M_NORM) ? tx_line : (chm == M_LOCAL) ? 1'b1 : rxd;
  assign rts_n = rxn == CW'(DEPTH);

  p_ovr_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(rxn) == CW'(DEPTH));
  p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !ovr_clr) |=> ovr);
  p_queue_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    txn <= CW'(DEPTH) && rxn <= CW'(DEPTH));
  p_remote_no_store_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (chm == M_REMOTE) |=> rxn <= $past(rxn));
  p_echo_no_write_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (chm == M_ECHO) |=> txn <= $past(txn));
  p_glitch_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_smp && rx_idx == 4'd0 && rx_in) |=> !rx_busy);
endmodule

// File: tb/tb_sio_channel.sv
module tb_sio_channel;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, rx_tick = 0, tx_tick = 0, rxd = 1;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  wire  [7:0] rdata;
  wire txd, rts_n;

  int total = 0, bad = 0;
  int rx_div = 4, tx_div = 4, rx_c = 0, tx_c = 0, tx_tc = 0;
  bit rx_run = 1, tx_run = 1;
  bit mon_on = 1, mon_x = 0;
  int mon_m = 1;
  int last_start = -1, start_gap = 0, mism = 0, lows = 0;
  bit cmp_on = 0, hi_on = 0;
  logic [8:0] expq[$];
  string tagq[$];
  logic [8:0] mgot;
  logic [8:0] mexp;
  string mtag;
  logic [7:0] v;

  always #10 clk = ~clk;

  sio_channel #(.DEPTH(4)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rx_tick(rx_tick), .tx_tick(tx_tick),
    .rxd(rxd), .txd(txd), .rts_n(rts_n));

  always @(negedge clk) begin
    rx_c = (rx_c + 1) % rx_div;
    tx_c = (tx_c + 1) % tx_div;
    rx_tick = rx_run && rx_c == 0;
    tx_tick = tx_run && tx_c == 0;
  end
  always @(posedge clk) begin
    if (tx_tick) tx_tc++;
    if (cmp_on && txd !== rxd) mism++;
    if (hi_on && txd !== 1'b1) lows++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] ex(logic [7:0] d, logic [1:0] p, bit f);
    case (p)
      2'd0: return {1'b0, d};
      2'd1: return {^d, d};
      2'd2: return {~^d, d};
      default: return {f, d};
    endcase
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic rd(input logic [1:0] a, input bit pop, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = pop; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask
  task automatic tx_put(input logic [7:0] d, input logic [8:0] e, input string tag);
    wr(0, d); expq.push_back(e); tagq.push_back(tag);
  endtask
  task automatic wait_rx;
    do @(posedge clk); while (!rx_tick);
    @(negedge clk);
  endtask
  task automatic wait_tx;
    do @(posedge clk); while (!tx_tick);
    @(negedge clk);
  endtask
  task automatic rx_send(input logic [7:0] d, input bit x, input bit usex, input bit stopv, input int m);
    wait_rx; rxd = 0; repeat (m) wait_rx;
    for (int i = 0; i < 8; i++) begin rxd = d[i]; repeat (m) wait_rx; end
    if (usex) begin rxd = x; repeat (m) wait_rx; end
    rxd = stopv; repeat (m) wait_rx;
    rxd = 1; repeat (2 * m) wait_rx;
  endtask
  task automatic wait_idle;
    logic [7:0] s;
    for (int i = 0; i < 5000; i++) begin rd(2, 0, s); if (s[3]) break; end
    repeat (20) wait_tx;
  endtask

  // scoreboard monitor on txd
  initial forever begin
    wait_tx;
    if (mon_on && txd === 1'b0) begin
      start_gap = (last_start < 0) ? 0 : tx_tc - last_start;
      last_start = tx_tc;
      mgot = '0;
      repeat (mon_m / 2) wait_tx;
      for (int i = 0; i < 8; i++) begin repeat (mon_m) wait_tx; mgot[i] = txd; end
      if (mon_x) begin repeat (mon_m) wait_tx; mgot[8] = txd; end
      repeat (mon_m) wait_tx;
      check("R2 stop bit high", txd, 1);
      if (expq.size() == 0) check("R2 unexpected frame on txd", {23'd0, mgot}, 32'hffff_ffff);
      else begin
        mexp = expq.pop_front(); mtag = tagq.pop_front();
        check(mtag, mgot, mexp);
      end
    end
  end

  initial begin
    #(150000 * 20);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(2, 0, v); check("R1 status", v, 8'h0c);
    rd(1, 0, v); check("R1 mode", v, 8'h00);
    check("R1 txd", txd, 1);
    check("R1 rts_n", rts_n, 0);

    // R3: fill transmit queue with ticks stopped, fifth write dropped
    tx_run = 0;
    for (int i = 0; i < 4; i++) tx_put(8'h30 + 8'(i), ex(8'h30 + 8'(i), 0, 0), "R2 R3 queued frame");
    wr(0, 8'hee);
    rd(2, 0, v); check("R3 full status", v, 8'h00);
    tx_run = 1;
    wait_idle;
    check("R3 all four sent", expq.size(), 0);

    // R7 parity on transmit
    wr(1, 8'h01); mon_x = 1;
    tx_put(8'h37, ex(8'h37, 1, 0), "R7 even parity tx");
    tx_put(8'h36, ex(8'h36, 1, 0), "R7 even parity tx");
    wait_idle;
    wr(1, 8'h02);
    tx_put(8'h37, ex(8'h37, 2, 0), "R7 odd parity tx");
    wait_idle;
    // R9 multidrop transmit
    wr(1, 8'h83); tx_put(8'h55, ex(8'h55, 3, 1), "R9 address flag tx");
    wr(1, 8'h03); tx_put(8'h55, ex(8'h55, 3, 0), "R9 data flag tx");
    wait_idle;
    check("R9 queue drained", expq.size(), 0);

    // R12 fractional stop in 16x transmit, then 1x ignores it
    wr(1, 8'h20); wr(3, 8'h05); mon_x = 0; mon_m = 16;
    tx_run = 0; last_start = -1;
    tx_put(8'ha1, ex(8'ha1, 0, 0), "R10 16x tx frame");
    tx_put(8'h1a, ex(8'h1a, 0, 0), "R10 16x tx frame");
    tx_run = 1;
    wait_idle;
    check("R12 16x start spacing", start_gap, 165);
    wr(1, 8'h00); mon_m = 1; tx_run = 0; last_start = -1;
    tx_put(8'h0f, ex(8'h0f, 0, 0), "R2 1x frame");
    tx_put(8'hf0, ex(8'hf0, 0, 0), "R2 1x frame");
    tx_run = 1;
    wait_idle;
    check("R12 1x start spacing", start_gap, 10);
    rd(3, 0, v); check("R12 fraction readback", v, 8'h05);

    // R4 receive, R5 flow control, R6 overrun
    rx_send(8'ha5, 0, 0, 1, 1);
    rd(2, 0, v); check("R4 status one char", v, 8'h0d);
    rd(0, 1, v); check("R4 data", v, 8'ha5);
    for (int i = 1; i <= 4; i++) begin
      rx_send(8'(i * 17), 0, 0, 1, 1);
      if (i == 3) check("R5 rts_n low at three", rts_n, 0);
    end
    check("R5 rts_n high when full", rts_n, 1);
    rd(2, 0, v); check("R4 full status", v, 8'h0f);
    rx_send(8'h99, 0, 0, 1, 1);
    rd(2, 0, v); check("R6 overrun set", v, 8'h1f);
    for (int i = 1; i <= 4; i++) begin
      rd(0, 1, v); check("R4 R6 order kept, newest lost", v, 8'(i * 17));
    end
    check("R5 rts_n low after drain", rts_n, 0);
    rd(2, 0, v); check("R6 overrun sticky", v, 8'h1c);
    wr(2, 8'h01);
    rd(2, 0, v); check("R6 overrun cleared", v, 8'h0c);

    // R7 receive parity
    wr(1, 8'h01);
    rx_send(8'h07, 1, 1, 1, 1);
    rd(2, 0, v); check("R7 even parity good", v, 8'h0d); rd(0, 1, v);
    rx_send(8'h07, 0, 1, 1, 1);
    rd(2, 0, v); check("R7 even parity error", v, 8'h2d); rd(0, 1, v);
    wr(1, 8'h02);
    rx_send(8'h07, 0, 1, 1, 1);
    rd(2, 0, v); check("R7 odd parity good", v, 8'h0d); rd(0, 1, v);
    // R8 framing
    wr(1, 8'h00);
    rx_send(8'h5a, 0, 0, 0, 1);
    rd(2, 0, v); check("R8 framing flag", v, 8'h4d);
    rd(0, 1, v); check("R8 data kept", v, 8'h5a);
    // R9 multidrop receive
    wr(1, 8'h03);
    rx_send(8'h21, 1, 1, 1, 1);
    rd(2, 0, v); check("R9 address flag rx", v, 8'h8d); rd(0, 1, v);
    rx_send(8'h21, 0, 1, 1, 1);
    rd(2, 0, v); check("R9 data flag rx", v, 8'h0d); rd(0, 1, v);

    // R11 glitch rejection, R10 16x receive
    wr(1, 8'h10);
    wait_rx; rxd = 0; repeat (3) wait_rx; rxd = 1; repeat (40) wait_rx;
    rd(2, 0, v); check("R11 glitch dropped", v, 8'h0c);
    rx_send(8'hc3, 0, 0, 1, 16);
    rd(2, 0, v); check("R10 16x rx status", v, 8'h0d);
    rd(0, 1, v); check("R10 16x rx data", v, 8'hc3);
    // R10 split rates
    rx_div = 5; tx_div = 3;
    fork
      rx_send(8'h6e, 0, 0, 1, 16);
      tx_put(8'h91, ex(8'h91, 0, 0), "R10 1x tx beside 16x rx");
    join
    wait_idle;
    rd(0, 1, v); check("R10 split-rate rx data", v, 8'h6e);
    rx_div = 4; tx_div = 4;

    // R13 echo
    wr(1, 8'h04); mon_on = 0;
    wr(0, 8'h77);
    cmp_on = 1; rx_send(8'h3b, 0, 0, 1, 1); cmp_on = 0;
    rd(2, 0, v); check("R13 echo stores, write dropped", v, 8'h0d);
    rd(0, 1, v); check("R13 echo data", v, 8'h3b);
    wr(1, 8'h00); mon_on = 1;
    repeat (30) wait_tx;
    rd(2, 0, v); check("R13 nothing queued after echo", v, 8'h0c);
    // R13 remote loopback
    wr(1, 8'h0c); mon_on = 0;
    cmp_on = 1; rx_send(8'h81, 0, 0, 1, 1); cmp_on = 0;
    rd(2, 0, v); check("R13 remote stores nothing", v, 8'h0c);
    check("R13 txd followed rxd", mism, 0);
    // R14 local loopback
    wr(1, 8'h08); hi_on = 1;
    wr(0, 8'h4d);
    repeat (30) wait_tx;
    hi_on = 0;
    rd(2, 0, v); check("R14 looped char stored", v, 8'h0d);
    rd(0, 1, v); check("R14 looped data", v, 8'h4d);
    check("R14 txd held high", lows, 0);
    wr(1, 8'h00); mon_on = 1;
    repeat (10) wait_tx;
    check("R2 scoreboard empty", expq.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule